// File: doc/BRIEF.md
# Byte-Granular Register-Pair Shifter

This block moves the magnitude bytes of sign-magnitude words by a whole number of bytes. It works on one register alone or on two registers joined into one double-length value, and it can rotate that joined value. Each word is a sign bit plus five 6-bit bytes. The byte count arrives already decoded. The block shifts only magnitudes and never changes either sign bit.

A caller presents the high word, the low word, a 3-bit mode and a byte count, and pulses `start` for one clock. On that edge the shifted words are registered, and `done` is high for the following cycle. The outputs then hold until the next strobe. A shift therefore costs a fixed two time units: one for the issuing cycle and one for the result cycle.

Word encoding used throughout: bit 30 is the sign (1 = negative), bits 29:24 are byte 1 (the most significant byte), and bits 5:0 are byte 5. In pair modes the high word's bytes are the most significant half of a 10-byte value.

Top module: `bsh_pair_shifter`

## Requirements
- R1: Mode code 0 shifts the high word's magnitude left by `count` bytes and fills the vacated low-order bytes with zero. The low word is returned unchanged.
- R2: Mode code 1 shifts the high word's magnitude right by `count` bytes and fills the vacated high-order bytes with zero. The low word is returned unchanged. A count of 0 returns both words unchanged.
- R3: In mode codes 0 and 1, a count of 5 or more returns an all-zero high magnitude.
- R4: Mode code 2 shifts the 10-byte pair (high word most significant) left by `count` bytes with zero fill.
- R5: Mode code 3 shifts the 10-byte pair right by `count` bytes with zero fill.
- R6: In mode codes 2 and 3, a count of 10 or more returns zero magnitudes in both words.
- R7: Mode codes 4 and 5 rotate the 10-byte pair left and right respectively, by `count` modulo 10 bytes.
- R8: In every mode, each output sign bit equals the corresponding input sign bit.
- R9: Results are registered on the clock edge where `start` is high. `done` is high for exactly the cycle after each strobe. Without a strobe, `done` is low and both outputs hold their values.
- R10: Mode codes 6 and 7 return both input words unchanged.
- R11: While `rst_n` is low, both outputs are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that launches a shift |
| mode | input | 3 | Shift mode code, 0 to 7 |
| count | input | 12 | Shift amount in bytes |
| hi_in | input | 31 | High word, sign and five bytes |
| lo_in | input | 31 | Low word, sign and five bytes |
| hi_out | output | 31 | Registered high result |
| lo_out | output | 31 | Registered low result |
| done | output | 1 | High one cycle after `start` |

## Verification
A vector table drives every mode with distinct byte values in all ten positions, so any misrouted lane shows up as a wrong byte value rather than a plausible one. Counts of 0, small, exactly the register length, exactly the pair length and far beyond it separate the clamping of single and pair modes from modulo wrapping in the rotate modes. Operands with opposite and equal signs show whether sign bits leak into the magnitude path. Directed steps check reset values, the one-cycle `done` pulse, and output hold when inputs change without a strobe.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
   typedef enum logic [2:0] {
      MD_ONE_L  = 3'd0,
      MD_ONE_R  = 3'd1,
      MD_PAIR_L = 3'd2,
      MD_PAIR_R = 3'd3,
      MD_ROT_L  = 3'd4,
      MD_ROT_R  = 3'd5
   } shift_mode_e;
endpackage

// File: rtl/bsh_count_norm.sv
// Folds the raw byte count into a small lane offset suited to the mode:
// clamped for zero-fill modes, wrapped for rotate modes.
module bsh_count_norm #(
   parameter int NBYTES = 5,
   parameter int CNT_W  = 12,
   localparam int TWO_N = 2 * NBYTES,
   localparam int AW    = $clog2(TWO_N + 1)
) (
   input  logic [2:0]       mode,
   input  logic [CNT_W-1:0] count,
   output logic [AW-1:0]    amt
);
   import bsh_pkg::*;

   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(NBYTES);
   localparam logic [CNT_W-1:0] C_TWO = CNT_W'(TWO_N);

   logic [CNT_W-1:0] wrap;

   always_comb begin
      wrap = count % C_TWO;
      unique case (mode)
         MD_ONE_L, MD_ONE_R:   amt = (count >= C_ONE) ? AW'(NBYTES) : AW'(count);
         MD_PAIR_L, MD_PAIR_R: amt = (count >= C_TWO) ? AW'(TWO_N)  : AW'(count);
         MD_ROT_L, MD_ROT_R:   amt = AW'(wrap);
         default:              amt = '0;
      endcase
   end
endmodule

// File: rtl/bsh_lane_net.sv
// One mux per output byte lane; lane 0 is the most significant byte of the pair.
module bsh_lane_net #(
   parameter int BYTE_W = 6,
   parameter int NBYTES = 5,
   localparam int TWO_N = 2 * NBYTES,
   localparam int AW    = $clog2(TWO_N + 1),
   localparam int SW    = $clog2(4 * NBYTES)
) (
   input  logic [2:0]        mode,
   input  logic [AW-1:0]     amt,
   input  logic [BYTE_W-1:0] lane_in  [TWO_N],
   output logic [BYTE_W-1:0] lane_out [TWO_N]
);
   import bsh_pkg::*;

   localparam logic [SW-1:0] S_N  = SW'(NBYTES);
   localparam logic [SW-1:0] S_2N = SW'(TWO_N);

   for (genvar j = 0; j < TWO_N; j++) begin : g_lane
      localparam logic [SW-1:0] S_J = SW'(j);
      localparam bit IN_HI = (j < NBYTES);
      logic [SW-1:0] src;
      logic [SW-1:0] a;
      logic          ok;

      always_comb begin
         a   = SW'(amt);
         src = S_J;
         ok  = 1'b1;
         unique case (mode)
            MD_ONE_L: if (IN_HI) begin
               src = S_J + a;
               ok  = (src < S_N);
            end
            MD_ONE_R: if (IN_HI) begin
               src = S_J - a;
               ok  = (S_J >= a);
            end
            MD_PAIR_L: begin
               src = S_J + a;
               ok  = (src < S_2N);
            end
            MD_PAIR_R: begin
               src = S_J - a;
               ok  = (S_J >= a);
            end
            MD_ROT_L: begin
               src = S_J + a;
               if (src >= S_2N) src = src - S_2N;
            end
            MD_ROT_R: begin
               src = S_J + S_2N - a;
               if (src >= S_2N) src = src - S_2N;
            end
            default: begin
               src = S_J;
               ok  = 1'b1;
            end
         endcase
      end

      always_comb begin
         lane_out[j] = '0;
         for (int k = 0; k < TWO_N; k++) begin
            if (ok && (src == SW'(k))) lane_out[j] = lane_in[k];
         end
      end
   end
endmodule

// File: rtl/bsh_pair_shifter.sv
module bsh_pair_shifter #(
   parameter int BYTE_W = 6,
   parameter int NBYTES = 5,
   parameter int CNT_W  = 12,
   localparam int MAG_W  = BYTE_W * NBYTES,
   localparam int WORD_W = MAG_W + 1,
   localparam int TWO_N  = 2 * NBYTES,
   localparam int AW     = $clog2(TWO_N + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [CNT_W-1:0]  count,
   input  logic [WORD_W-1:0] hi_in,
   input  logic [WORD_W-1:0] lo_in,
   output logic [WORD_W-1:0] hi_out,
   output logic [WORD_W-1:0] lo_out,
   output logic              done
);
   if (BYTE_W < 1 || NBYTES < 1) begin : g_bad_geom
      $error("bsh_pair_shifter: BYTE_W and NBYTES must be positive");
   end
   if ((1 << CNT_W) <= TWO_N) begin : g_bad_cnt
      $error("bsh_pair_shifter: CNT_W too narrow to reach the pair length");
   end

   logic [BYTE_W-1:0] lanes_in  [TWO_N];
   logic [BYTE_W-1:0] lanes_out [TWO_N];
   logic [MAG_W-1:0]  hi_mag, lo_mag;
   logic [AW-1:0]     amt;

   for (genvar j = 0; j < NBYTES; j++) begin : g_split
      localparam int LSB = (NBYTES - 1 - j) * BYTE_W;
      assign lanes_in[j]          = hi_in[LSB +: BYTE_W];
      assign lanes_in[j + NBYTES] = lo_in[LSB +: BYTE_W];
      assign hi_mag[LSB +: BYTE_W] = lanes_out[j];
      assign lo_mag[LSB +: BYTE_W] = lanes_out[j + NBYTES];
   end

   bsh_count_norm #(.NBYTES(NBYTES), .CNT_W(CNT_W)) u_norm (
      .mode (mode),
      .count(count),
      .amt  (amt)
   );

   bsh_lane_net #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_net (
      .mode    (mode),
      .amt     (amt),
      .lane_in (lanes_in),
      .lane_out(lanes_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_out <= '0;
         lo_out <= '0;
         done   <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            hi_out <= {hi_in[MAG_W], hi_mag};
            lo_out <= {lo_in[MAG_W], lo_mag};
         end
      end
   end

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);                                                  // R9
   AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);                                                // R9
   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(hi_out) && $stable(lo_out)));                 // R9
   AST_SIGNS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (hi_out[MAG_W] == $past(hi_in[MAG_W]) &&
                 lo_out[MAG_W] == $past(lo_in[MAG_W])));                // R8
   AST_LO_UNTOUCHED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode <= 3'd1) |=> (lo_out == $past(lo_in)));            // R1
   AST_PAIR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (mode == 3'd2 || mode == 3'd3) && count >= CNT_W'(TWO_N))
      |=> (hi_out[MAG_W-1:0] == '0 && lo_out[MAG_W-1:0] == '0));        // R6
   AST_SINGLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode <= 3'd1 && count >= CNT_W'(NBYTES))
      |=> (hi_out[MAG_W-1:0] == '0));                                   // R3
endmodule

// File: tb/bsh_pair_shifter_bench.sv
`timescale 1ns/1ps
module bsh_pair_shifter_bench;
   localparam int W = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    mode = '0;
   logic [11:0]   count = '0;
   logic [W-1:0]  hi_in = '0, lo_in = '0;
   logic [W-1:0]  hi_out, lo_out;
   logic          done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   bsh_pair_shifter u_bsh_pair_shifter (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
      .hi_in(hi_in), .lo_in(lo_in), .hi_out(hi_out), .lo_out(lo_out), .done(done)
   );

   function automatic logic [W-1:0] mk(int s, int b1, int b2, int b3, int b4, int b5);
      return {1'(s), 6'(b1), 6'(b2), 6'(b3), 6'(b4), 6'(b5)};
   endfunction

   typedef struct packed {
      logic [3:0]   req;
      logic [2:0]   md;
      logic [11:0]  cnt;
      logic [W-1:0] hi, lo, ehi, elo;
   } vec_t;

   localparam logic [W-1:0] NEG = mk(1, 1, 2, 3, 4, 5);
   localparam logic [W-1:0] PA  = mk(0, 1, 2, 3, 4, 5);
   localparam logic [W-1:0] NB  = mk(1, 6, 7, 8, 9, 10);
   localparam logic [W-1:0] ZP  = mk(0, 0, 0, 0, 0, 0);
   localparam logic [W-1:0] ZN  = mk(1, 0, 0, 0, 0, 0);

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{4'd1,  3'd0, 12'd2,    NEG, NB, mk(1, 3, 4, 5, 0, 0), NB},        // R1
      '{4'd2,  3'd1, 12'd1,    NEG, NB, mk(1, 0, 1, 2, 3, 4), NB},        // R2
      '{4'd3,  3'd0, 12'd5,    NEG, NB, ZN, NB},                          // R3
      '{4'd3,  3'd1, 12'd4000, NEG, NB, ZN, NB},                          // R3
      '{4'd4,  3'd2, 12'd3,    PA,  NB, mk(0, 4, 5, 6, 7, 8), mk(1, 9, 10, 0, 0, 0)}, // R4
      '{4'd4,  3'd2, 12'd5,    PA,  NB, mk(0, 6, 7, 8, 9, 10), ZN},       // R4
      '{4'd5,  3'd3, 12'd3,    PA,  NB, mk(0, 0, 0, 0, 1, 2), mk(1, 3, 4, 5, 6, 7)}, // R5
      '{4'd6,  3'd3, 12'd10,   PA,  NB, ZP, ZN},                          // R6
      '{4'd6,  3'd2, 12'd11,   PA,  NB, ZP, ZN},                          // R6
      '{4'd7,  3'd4, 12'd3,    PA,  NB, mk(0, 4, 5, 6, 7, 8), mk(1, 9, 10, 1, 2, 3)}, // R7
      '{4'd7,  3'd5, 12'd24,   PA,  NB, mk(0, 7, 8, 9, 10, 1), mk(1, 2, 3, 4, 5, 6)}, // R7
      '{4'd7,  3'd4, 12'd10,   PA,  NB, PA, NB},                          // R7
      '{4'd8,  3'd2, 12'd1,    NEG, NB, mk(1, 2, 3, 4, 5, 6), mk(1, 7, 8, 9, 10, 0)}, // R8
      '{4'd10, 3'd6, 12'd3,    PA,  NB, PA, NB},                          // R10
      '{4'd10, 3'd7, 12'd0,    NEG, NB, NEG, NB},                         // R10
      '{4'd2,  3'd1, 12'd0,    PA,  NB, PA, NB}                           // R2
   };

   task automatic chk(int req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      // R11: reset state
      repeat (3) @(posedge clk);
      #2;
      chk(11, "reset hi_out", hi_out, '0);
      chk(11, "reset lo_out", lo_out, '0);
      chk(11, "reset done", W'(done), '0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         mode  = VECS[i].md;
         count = VECS[i].cnt;
         hi_in = VECS[i].hi;
         lo_in = VECS[i].lo;
         start = 1'b1;
         @(posedge clk);
         #2;
         chk(int'(VECS[i].req), $sformatf("vec %0d hi", i), hi_out, VECS[i].ehi);
         chk(int'(VECS[i].req), $sformatf("vec %0d lo", i), lo_out, VECS[i].elo);
         chk(9, $sformatf("vec %0d done", i), W'(done), W'(1));
         @(negedge clk) start = 1'b0;
      end

      // R9: no strobe -> done drops, outputs hold although inputs change
      @(negedge clk);
      mode = 3'd2; count = 12'd1; hi_in = NEG; lo_in = PA;
      @(posedge clk);
      #2;
      chk(9, "idle done", W'(done), '0);
      chk(9, "idle hold hi", hi_out, PA);
      chk(9, "idle hold lo", lo_out, NB);

      // R1: single left by 4, low word passes through
      @(negedge clk);
      mode = 3'd0; count = 12'd4; hi_in = PA; lo_in = NEG; start = 1'b1;
      @(posedge clk);
      #2;
      chk(1, "left4 hi", hi_out, mk(0, 5, 0, 0, 0, 0));
      chk(1, "left4 lo", lo_out, NEG);
      @(negedge clk) start = 1'b0;
      @(posedge clk);
      #2;
      chk(9, "pulse width", W'(done), '0);

      // R11: reset clears after activity
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk);
      #2;
      chk(11, "re-reset hi", hi_out, '0);
      chk(11, "re-reset lo", lo_out, '0);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         n_bad++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule